// File: doc/BRIEF.md
# Snoop Response Combiner

On a snooping bus where transactions are atomic, every cache compares the address of a transaction against its own tags. The caches then report what they found. This block collects those reports for one transaction and turns them into the collective result. Each of `N_CACHES` snoopers presents three signals: a completion strobe, a "holds a copy" flag and a "holds a modified copy" flag. The block latches each snooper's answer when its completion strobe arrives. The wired-OR that a physical bus would perform is done here by explicit OR reduction.

The result-valid line stays low until every snooper has answered. The shared and dirty lines may be sampled only once result-valid is high. The dirty result decides whether main memory supplies the data: when a modified copy exists, a cache supplies it instead. The shared result tells a requester on a read miss whether to install the line Exclusive or Shared. A watchdog flags a transaction whose snoopers have not all answered within `TIMEOUT` cycles of the address phase. All outputs are registered.

Top module: `snoop_combiner`

## Requirements
- R1: While `rst` is high, and on the first sampling point after it is released, `res_valid`, `res_shared`, `res_dirty`, `mem_respond`, `fill_excl` and `snoop_timeout` are all 0.
- R2: A high `addr_phase` at a clock edge opens a new transaction and clears every latched answer and all outputs. Snooper inputs presented in the same cycle as `addr_phase` are not counted.
- R3: A snooper's `snp_hit` and `snp_mod` bits are captured only in a cycle where its `snp_done` bit is high. A hit or modified bit shown without done has no effect on the result.
- R4: `res_valid` rises at the clock edge that ends the cycle in which the last outstanding snooper presents `snp_done`. Until then it stays 0.
- R5: When `res_valid` is 1, `res_shared` is the OR of the captured hit bits of all snoopers.
- R6: When `res_valid` is 1, `res_dirty` is the OR of the captured modified bits of all snoopers.
- R7: `mem_respond` is 1 exactly when `res_valid` is 1 and `res_dirty` is 0.
- R8: `fill_excl` is 1 exactly when `res_valid` is 1, `res_shared` is 0 and `rd_miss` was high with `addr_phase`. `rd_miss` is sampled only in that cycle.
- R9: Once `res_valid` is 1, all outputs hold their values until `txn_end` or `addr_phase`. Further snooper inputs are ignored.
- R10: A high `txn_end` (without `addr_phase`) closes the transaction, and all outputs read 0 after that edge. `addr_phase` wins if both are high.
- R11: If `res_valid` has not risen by the `TIMEOUT`-th clock edge after the `addr_phase` edge, `snoop_timeout` rises at that edge. Completion at that same edge wins over the timeout. The flag then holds until `txn_end` or `addr_phase`.
- R12: Between `txn_end` and the next `addr_phase`, snooper inputs are ignored and every output stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_phase | input | 1 | Address phase of a new transaction |
| rd_miss | input | 1 | Transaction is a read miss, sampled with `addr_phase` |
| txn_end | input | 1 | End of the current transaction |
| snp_done | input | N_CACHES | Per-snooper lookup complete strobe |
| snp_hit | input | N_CACHES | Per-snooper "holds a copy", valid with done |
| snp_mod | input | N_CACHES | Per-snooper "holds a modified copy", valid with done |
| res_valid | output | 1 | Collective result may be sampled |
| res_shared | output | 1 | Some snooper holds a copy |
| res_dirty | output | 1 | Some snooper holds a modified copy |
| mem_respond | output | 1 | Memory should supply the data |
| fill_excl | output | 1 | Requester installs the line Exclusive (else Shared) |
| snoop_timeout | output | 1 | Snoopers did not all answer within `TIMEOUT` cycles |

## Verification
The hardest cases to reach are at the edges of the timing window. One is the last snooper answering exactly on the `TIMEOUT`-th edge, where completion must beat the watchdog. The other is a snooper answering exactly one cycle later, which must raise the flag first. The stimulus gives each snooper a random answer cycle under a fixed seed, so answers often coincide or spread out. Directed transactions then place the final answer at those two boundary cycles. Those transactions also show hit bits without done, answers during the address phase, stray answers after the result and answers between transactions.

// File: rtl/snoop_comb_pkg.sv
package snoop_comb_pkg;
  typedef struct packed {
    logic shared;
    logic dirty;
  } snoop_sum_t;
endpackage

// File: rtl/snoop_slot.sv
// Per-snooper answer latch: captures hit/modified with the done strobe.
module snoop_slot (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic capture_en,
  input  logic done_i,
  input  logic hit_i,
  input  logic mod_i,
  output logic seen_o,
  output logic hit_seen_o,
  output logic mod_seen_o
);
  logic done_q, hit_q, mod_q;
  logic take;

  assign take       = capture_en & done_i & ~done_q;
  assign seen_o     = done_q | take;
  assign hit_seen_o = hit_q | (take & hit_i);
  assign mod_seen_o = mod_q | (take & mod_i);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      done_q <= 1'b0;
      hit_q  <= 1'b0;
      mod_q  <= 1'b0;
    end else if (take) begin
      done_q <= 1'b1;
      hit_q  <= hit_i;
      mod_q  <= mod_i;
    end
  end
endmodule

// File: rtl/snoop_reduce.sv
// Explicit OR/AND reduction standing in for the wired-OR bus lines.
module snoop_reduce
  import snoop_comb_pkg::*;
#(
  parameter int N_CACHES = 4
) (
  input  logic [N_CACHES-1:0] seen_i,
  input  logic [N_CACHES-1:0] hit_i,
  input  logic [N_CACHES-1:0] mod_i,
  output logic                all_seen_o,
  output snoop_sum_t          sum_o
);
  assign all_seen_o   = &seen_i;
  assign sum_o.shared = |hit_i;
  assign sum_o.dirty  = |mod_i;
endmodule

// File: rtl/snoop_timer.sv
// Counts cycles since the address phase; expire pulses on the LIMIT-th edge.
module snoop_timer #(
  parameter int LIMIT = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic expire
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
  localparam logic [CW-1:0] TOP  = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  assign expire = run && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear) cnt_q <= '0;
    else if (run && cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/snoop_combiner.sv
module snoop_combiner
  import snoop_comb_pkg::*;
#(
  parameter int N_CACHES = 4,
  parameter int TIMEOUT  = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                addr_phase,
  input  logic                rd_miss,
  input  logic                txn_end,
  input  logic [N_CACHES-1:0] snp_done,
  input  logic [N_CACHES-1:0] snp_hit,
  input  logic [N_CACHES-1:0] snp_mod,
  output logic                res_valid,
  output logic                res_shared,
  output logic                res_dirty,
  output logic                mem_respond,
  output logic                fill_excl,
  output logic                snoop_timeout
);
  logic active_q, valid_q, shared_q, dirty_q, rdmiss_q, mem_q, excl_q, tmo_q;
  logic clear, capture_en, all_seen, expire;
  logic [N_CACHES-1:0] seen, hit_seen, mod_seen;
  snoop_sum_t sum;

  assign clear      = addr_phase | txn_end;
  assign capture_en = active_q & ~valid_q;

  for (genvar i = 0; i < N_CACHES; i++) begin : g_slot
    snoop_slot u_slot (
      .clk        (clk),
      .rst        (rst),
      .clear      (clear),
      .capture_en (capture_en),
      .done_i     (snp_done[i]),
      .hit_i      (snp_hit[i]),
      .mod_i      (snp_mod[i]),
      .seen_o     (seen[i]),
      .hit_seen_o (hit_seen[i]),
      .mod_seen_o (mod_seen[i])
    );
  end

  snoop_reduce #(.N_CACHES(N_CACHES)) u_reduce (
    .seen_i     (seen),
    .hit_i      (hit_seen),
    .mod_i      (mod_seen),
    .all_seen_o (all_seen),
    .sum_o      (sum)
  );

  snoop_timer #(.LIMIT(TIMEOUT)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .clear  (clear),
    .run    (capture_en & ~tmo_q),
    .expire (expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0; valid_q <= 1'b0; shared_q <= 1'b0; dirty_q <= 1'b0;
      rdmiss_q <= 1'b0; mem_q   <= 1'b0; excl_q   <= 1'b0; tmo_q   <= 1'b0;
    end else if (addr_phase) begin
      active_q <= 1'b1; valid_q <= 1'b0; shared_q <= 1'b0; dirty_q <= 1'b0;
      rdmiss_q <= rd_miss; mem_q <= 1'b0; excl_q  <= 1'b0; tmo_q   <= 1'b0;
    end else if (txn_end) begin
      active_q <= 1'b0; valid_q <= 1'b0; shared_q <= 1'b0; dirty_q <= 1'b0;
      rdmiss_q <= 1'b0; mem_q   <= 1'b0; excl_q   <= 1'b0; tmo_q   <= 1'b0;
    end else if (capture_en) begin
      if (all_seen) begin
        valid_q  <= 1'b1;
        shared_q <= sum.shared;
        dirty_q  <= sum.dirty;
        mem_q    <= ~sum.dirty;
        excl_q   <= rdmiss_q & ~sum.shared;
      end else if (expire) begin
        tmo_q <= 1'b1;
      end
    end
  end

  assign res_valid     = valid_q;
  assign res_shared    = shared_q;
  assign res_dirty     = dirty_q;
  assign mem_respond   = mem_q;
  assign fill_excl     = excl_q;
  assign snoop_timeout = tmo_q;
endmodule

// File: rtl/snoop_combiner_checker.sv
module snoop_combiner_checker (
  input logic clk,
  input logic rst,
  input logic addr_phase,
  input logic txn_end,
  input logic res_valid,
  input logic res_shared,
  input logic res_dirty,
  input logic mem_respond,
  input logic fill_excl,
  input logic snoop_timeout
);
  assert_open_clears_R2: assert property (@(posedge clk) disable iff (rst)
    addr_phase |=> !res_valid && !snoop_timeout);

  assert_mem_gate_R7: assert property (@(posedge clk) disable iff (rst)
    mem_respond |-> res_valid && !res_dirty);

  assert_excl_gate_R8: assert property (@(posedge clk) disable iff (rst)
    fill_excl |-> res_valid && !res_shared);

  assert_lines_gated_R4: assert property (@(posedge clk) disable iff (rst)
    (res_shared || res_dirty) |-> res_valid);

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !addr_phase && !txn_end) |=>
      res_valid && $stable(res_shared) && $stable(res_dirty) &&
      $stable(mem_respond) && $stable(fill_excl));

  assert_close_R10: assert property (@(posedge clk) disable iff (rst)
    (txn_end && !addr_phase) |=> !res_valid && !snoop_timeout);

  assert_timeout_rise_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(snoop_timeout) |-> !res_valid);
endmodule

bind snoop_combiner snoop_combiner_checker u_chk (
  .clk           (clk),
  .rst           (rst),
  .addr_phase    (addr_phase),
  .txn_end       (txn_end),
  .res_valid     (res_valid),
  .res_shared    (res_shared),
  .res_dirty     (res_dirty),
  .mem_respond   (mem_respond),
  .fill_excl     (fill_excl),
  .snoop_timeout (snoop_timeout)
);

// File: tb/snoop_combiner_test.sv
`timescale 1ns/1ps
module snoop_combiner_test;
  localparam int N  = 4;
  localparam int TO = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic addr_phase = 1'b0, rd_miss = 1'b0, txn_end = 1'b0;
  logic [N-1:0] snp_done = '0, snp_hit = '0, snp_mod = '0;
  logic res_valid, res_shared, res_dirty, mem_respond, fill_excl, snoop_timeout;

  int total = 0;
  int bad = 0;
  int seed = 32'h5A17;
  bit finished = 0;

  int tdone [N];
  bit thit  [N];
  bit tmod  [N];

  always #2 clk = ~clk;

  snoop_combiner #(.N_CACHES(N), .TIMEOUT(TO)) uut (
    .clk(clk), .rst(rst), .addr_phase(addr_phase), .rd_miss(rd_miss),
    .txn_end(txn_end), .snp_done(snp_done), .snp_hit(snp_hit), .snp_mod(snp_mod),
    .res_valid(res_valid), .res_shared(res_shared), .res_dirty(res_dirty),
    .mem_respond(mem_respond), .fill_excl(fill_excl), .snoop_timeout(snoop_timeout)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_or(input bit sel_mod);
    bit r = 0;
    for (int i = 0; i < N; i++) r |= sel_mod ? tmod[i] : thit[i];
    return r;
  endfunction

  task automatic check_all(input string req, input bit v, input bit sh, input bit dt,
                           input bit rm, input bit tmo);
    chk(req, "valid",   res_valid,     v);
    chk("R5", "shared", res_shared,    v & sh);
    chk("R6", "dirty",  res_dirty,     v & dt);
    chk("R7", "mem",    mem_respond,   v & ~dt);
    chk("R8", "excl",   fill_excl,     v & rm & ~sh);
    chk("R11", "tmo",   snoop_timeout, tmo);
  endtask

  // One transaction: tdone/thit/tmod preset; last = max answer cycle.
  task automatic run_txn(input bit rm, input bit junk);
    int last = 0;
    bit sh, dt;
    for (int i = 0; i < N; i++) if (tdone[i] > last) last = tdone[i];
    sh = exp_or(0);
    dt = exp_or(1);
    @(negedge clk);
    addr_phase = 1'b1; rd_miss = rm;
    if (junk) begin snp_done = '1; snp_hit = '1; snp_mod = '1; end  // R2: ignored
    @(negedge clk);
    addr_phase = 1'b0; rd_miss = ~rm;
    check_all("R2", 0, 0, 0, 0, 0);
    for (int c = 1; c <= last + 3; c++) begin
      for (int i = 0; i < N; i++) begin
        if (tdone[i] == c) begin
          snp_done[i] = 1'b1; snp_hit[i] = thit[i]; snp_mod[i] = tmod[i];
        end else if (c > last) begin
          snp_done[i] = 1'b1; snp_hit[i] = 1'b1; snp_mod[i] = 1'b1;  // R9 stray
        end else begin
          snp_done[i] = 1'b0; snp_hit[i] = 1'($urandom); snp_mod[i] = 1'($urandom); // R3
        end
      end
      @(negedge clk);
      check_all(c >= last ? "R9" : "R4", c >= last, sh, dt, rm,
                (c >= TO) && (last > TO));
    end
    snp_done = '0; snp_hit = '0; snp_mod = '0;
    txn_end = 1'b1;
    @(negedge clk);
    txn_end = 1'b0;
    check_all("R10", 0, 0, 0, 0, 0);
    snp_done = '1; snp_hit = '1; snp_mod = '1;  // R12: outside a transaction
    @(negedge clk);
    snp_done = '0; snp_hit = '0; snp_mod = '0;
    @(negedge clk);
    check_all("R12", 0, 0, 0, 0, 0);
  endtask

  initial begin
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check_all("R1", 0, 0, 0, 0, 0);
    rst = 1'b0;
    @(negedge clk);
    check_all("R1", 0, 0, 0, 0, 0);

    // Directed: clean read miss, exclusive fill
    for (int i = 0; i < N; i++) begin tdone[i] = i + 1; thit[i] = 0; tmod[i] = 0; end
    run_txn(1, 1);
    // Directed: one dirty owner, all answer in the same cycle
    for (int i = 0; i < N; i++) begin tdone[i] = 2; thit[i] = (i == 1); tmod[i] = (i == 1); end
    run_txn(1, 0);
    // Boundary R11: last answer exactly on the TO-th edge -> completion wins
    for (int i = 0; i < N; i++) begin tdone[i] = (i == 0) ? TO : 1; thit[i] = (i == 2); tmod[i] = 0; end
    run_txn(1, 0);
    // Boundary R11: one cycle late -> timeout first, result still arrives
    for (int i = 0; i < N; i++) begin tdone[i] = (i == 3) ? TO + 1 : 3; thit[i] = 0; tmod[i] = 0; end
    run_txn(0, 1);

    for (int t = 0; t < 60; t++) begin
      for (int i = 0; i < N; i++) begin
        tdone[i] = 1 + int'($urandom_range(0, 9));
        thit[i]  = ($urandom_range(0, 3) == 0);
        tmod[i]  = thit[i] && ($urandom_range(0, 2) == 0);
      end
      run_txn(1'($urandom), 1'($urandom));
    end
    finished = 1;
  end

  initial begin
    for (int k = 0; k < 100000 && !finished; k++) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule